// File: doc/BRIEF.md
# Subroutine Stack Sequencer

This block carries out the stack half of the control-transfer instructions of an 8-bit processor with a 16-bit address space: subroutine calls (plain and conditional), returns (plain and conditional), the eight single-byte restart vectors, and the two prefixed returns used at the end of interrupt handlers. It owns the program counter and the stack pointer. It drives a byte-wide memory port whose read data arrives one clock after the address is presented. An instruction is handed over in one cycle as an opcode, a prefix flag, the 16-bit operand and a condition result already worked out elsewhere. The block then steps through its push or pop cycles, updates PC and SP, and ends with a one-cycle done pulse. That pulse carries the instruction's T-state cost, so the surrounding core can keep its timing budget.

The interrupt-enable pair is also kept here. Another part of the core loads both bits through a write strobe while the sequencer is idle. The non-maskable flavour of the prefixed return copies the second bit into the first. Fetch, condition flags and interrupt acceptance all live outside the block.

Top module: `stack_seq`

## Requirements
- R1: After reset, pc=0x0000, sp=0xFFFF, iff1=iff2=0, and busy, done, mem_we and mem_rd are all 0.
- R2: A performed call (opcode 0xCD, or 11ccc100 with cond_ok=1) writes the high byte of pc+3 to sp-1 in the first cycle after acceptance and the low byte to sp-2 in the second. It then sets sp to sp-2 and pc to the operand, and pulses done with done_ts=17 in the third cycle after acceptance.
- R3: A skipped conditional call (11ccc100 with cond_ok=0) makes no memory access, sets pc to pc+3, leaves sp unchanged, and pulses done with done_ts=10 in the first cycle after acceptance.
- R4: A return (0xC9, or 11ccc000 with cond_ok=1) reads sp then sp+1 in consecutive cycles. It loads pc with {byte at sp+1, byte at sp} and sets sp to sp+2, then pulses done four cycles after acceptance with done_ts=10 for 0xC9 and 11 for the conditional form.
- R5: A skipped conditional return (11ccc000 with cond_ok=0) makes no memory access, sets pc to pc+1, and pulses done with done_ts=5 one cycle after acceptance.
- R6: A restart 11bbb111 pushes pc+1 in the same way as R2, then sets pc to bbb*8 (0x0000 to 0x0038) and pulses done with done_ts=11.
- R7: With ed_pfx=1, opcode 0x4D (interrupt return) and 0x45 (non-maskable return) pop pc as in R4 and report done_ts=14. 0x45 also copies iff2 into iff1, while 0x4D leaves both bits unchanged.
- R8: All SP and stack address arithmetic wraps modulo 2^16.
- R9: A start pulse while busy=1 is ignored. An opcode that is none of the above (including any prefixed byte other than 0x4D and 0x45) is ignored: busy stays 0 and pc and sp do not change.
- R10: iff_we loads iff1_in and iff2_in into iff1 and iff2 only while busy=0.
- R11: done is high for exactly one cycle per accepted instruction, and done_ts is 0 whenever done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction hand-over strobe |
| ed_pfx | input | 1 | Opcode follows the 0xED prefix |
| opcode | input | 8 | Opcode byte |
| operand | input | 16 | Immediate target address |
| cond_ok | input | 1 | Pre-evaluated condition result |
| iff_we | input | 1 | Load strobe for the interrupt-enable pair |
| iff1_in | input | 1 | Value for iff1 |
| iff2_in | input | 1 | Value for iff2 |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, one cycle after address |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| iff1 | output | 1 | Interrupt enable bit 1 |
| iff2 | output | 1 | Interrupt enable bit 2 |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |
| done_ts | output | 5 | T-state cost, valid with done |

## Verification
A wrong SP shows up on the memory address bus in the first push or pop cycle of the next stack instruction, and on the sp port as soon as the instruction that corrupted it completes. A wrong pushed return address is only exposed when the stack bytes are compared with pc+3 or pc+1 straight after the call. A wrong pop order is exposed at the done pulse of the return. A latency or cost error appears in the same done pulse as a wrong cycle count or a wrong done_ts. The bench runs every opcode with and without the prefix, under both condition values, against an arithmetic model of PC, SP and the stack bytes.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  localparam int AW  = 16;
  localparam int DW  = 8;
  localparam int TSW = 5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_H,
    S_PUSH_L,
    S_POP_L,
    S_POP_H,
    S_POP_W,
    S_FIN
  } seq_st_e;

  typedef struct packed {
    logic           valid;
    logic           skip;
    logic           push;
    logic           nmi_ret;
    logic [1:0]     len;
    logic [TSW-1:0] ts;
    logic [AW-1:0]  tgt;
  } dec_t;

endpackage

// File: rtl/stack_seq_decode.sv
module stack_seq_decode
  import stack_seq_pkg::*;
(
  input  logic          ed_pfx,
  input  logic [7:0]    opcode,
  input  logic [AW-1:0] operand,
  input  logic          cond_ok,
  output dec_t          dec
);

  logic is_ccall, is_cret, is_rst;

  assign is_ccall = (opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b100);
  assign is_cret  = (opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b000);
  assign is_rst   = (opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b111);

  always_comb begin
    dec = '0;
    if (ed_pfx) begin
      if (opcode == 8'h4D || opcode == 8'h45) begin
        dec.valid   = 1'b1;
        dec.len     = 2'd2;
        dec.ts      = TSW'(14);
        dec.nmi_ret = (opcode == 8'h45);
      end
    end else if (opcode == 8'hCD) begin
      dec.valid = 1'b1;
      dec.push  = 1'b1;
      dec.len   = 2'd3;
      dec.ts    = TSW'(17);
      dec.tgt   = operand;
    end else if (is_ccall) begin
      dec.valid = 1'b1;
      dec.len   = 2'd3;
      dec.tgt   = operand;
      if (cond_ok) begin
        dec.push = 1'b1;
        dec.ts   = TSW'(17);
      end else begin
        dec.skip = 1'b1;
        dec.ts   = TSW'(10);
      end
    end else if (opcode == 8'hC9) begin
      dec.valid = 1'b1;
      dec.len   = 2'd1;
      dec.ts    = TSW'(10);
    end else if (is_cret) begin
      dec.valid = 1'b1;
      dec.len   = 2'd1;
      if (cond_ok) begin
        dec.ts = TSW'(11);
      end else begin
        dec.skip = 1'b1;
        dec.ts   = TSW'(5);
      end
    end else if (is_rst) begin
      dec.valid = 1'b1;
      dec.push  = 1'b1;
      dec.len   = 2'd1;
      dec.ts    = TSW'(11);
      dec.tgt   = {{(AW-6){1'b0}}, opcode[5:3], 3'b000};
    end
  end

endmodule

// File: rtl/stack_seq_core.sv
module stack_seq_core
  import stack_seq_pkg::*;
#(
  parameter logic [AW-1:0] PC_RESET = '0,
  parameter logic [AW-1:0] SP_RESET = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  dec_t           dec,
  input  logic           iff_we,
  input  logic           iff1_in,
  input  logic           iff2_in,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           mem_we,
  output logic           mem_rd,
  input  logic [DW-1:0]  mem_rdata,
  output logic [AW-1:0]  pc,
  output logic [AW-1:0]  sp,
  output logic           iff1,
  output logic           iff2,
  output logic           busy,
  output logic           done,
  output logic [TSW-1:0] done_ts
);

  seq_st_e        st_q, st_n;
  logic [AW-1:0]  pc_q, pc_n, sp_q, sp_n;
  logic [AW-1:0]  ret_q, ret_n, tgt_q, tgt_n;
  logic [DW-1:0]  lo_q, lo_n;
  logic [TSW-1:0] ts_q, ts_n;
  logic           nmi_q, nmi_n;
  logic           iff1_q, iff1_n, iff2_q, iff2_n;
  logic           accept, iff_load;

  assign accept   = (st_q == S_IDLE) && start && dec.valid;
  assign iff_load = (st_q == S_IDLE) && iff_we;

  // next-state process
  always_comb begin
    st_n   = st_q;
    pc_n   = pc_q;
    sp_n   = sp_q;
    ret_n  = ret_q;
    tgt_n  = tgt_q;
    lo_n   = lo_q;
    ts_n   = ts_q;
    nmi_n  = nmi_q;
    iff1_n = iff1_q;
    iff2_n = iff2_q;
    unique case (st_q)
      S_IDLE: begin
        if (iff_load) begin
          iff1_n = iff1_in;
          iff2_n = iff2_in;
        end
        if (accept) begin
          ts_n  = dec.ts;
          nmi_n = dec.nmi_ret;
          tgt_n = dec.tgt;
          ret_n = pc_q + AW'(dec.len);
          if (dec.skip) begin
            pc_n = pc_q + AW'(dec.len);
            st_n = S_FIN;
          end else if (dec.push) begin
            st_n = S_PUSH_H;
          end else begin
            st_n = S_POP_L;
          end
        end
      end
      S_PUSH_H: st_n = S_PUSH_L;
      S_PUSH_L: begin
        sp_n = sp_q - AW'(2);
        pc_n = tgt_q;
        st_n = S_FIN;
      end
      S_POP_L: st_n = S_POP_H;
      S_POP_H: begin
        lo_n = mem_rdata;
        st_n = S_POP_W;
      end
      S_POP_W: begin
        pc_n = {mem_rdata, lo_q};
        sp_n = sp_q + AW'(2);
        if (nmi_q) iff1_n = iff2_q;
        st_n = S_FIN;
      end
      S_FIN:   st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pc_q   <= PC_RESET;
      sp_q   <= SP_RESET;
      ret_q  <= '0;
      tgt_q  <= '0;
      lo_q   <= '0;
      ts_q   <= '0;
      nmi_q  <= 1'b0;
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      pc_q   <= pc_n;
      sp_q   <= sp_n;
      iff1_q <= iff1_n;
      iff2_q <= iff2_n;
      if (accept) begin
        ret_q <= ret_n;
        tgt_q <= tgt_n;
        ts_q  <= ts_n;
        nmi_q <= nmi_n;
      end
      if (st_q == S_POP_H) lo_q <= lo_n;
    end
  end

  // memory port and status outputs
  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we    = 1'b0;
    mem_rd    = 1'b0;
    unique case (st_q)
      S_PUSH_H: begin
        mem_we    = 1'b1;
        mem_addr  = sp_q - AW'(1);
        mem_wdata = ret_q[AW-1:AW-DW];
      end
      S_PUSH_L: begin
        mem_we    = 1'b1;
        mem_addr  = sp_q - AW'(2);
        mem_wdata = ret_q[DW-1:0];
      end
      S_POP_L: begin
        mem_rd   = 1'b1;
        mem_addr = sp_q;
      end
      S_POP_H: begin
        mem_rd   = 1'b1;
        mem_addr = sp_q + AW'(1);
      end
      default: ;
    endcase
  end

  assign pc      = pc_q;
  assign sp      = sp_q;
  assign iff1    = iff1_q;
  assign iff2    = iff2_q;
  assign busy    = (st_q != S_IDLE);
  assign done    = (st_q == S_FIN);
  assign done_ts = done ? ts_q : '0;

  // R2: low byte goes one address below the high byte, on the next cycle
  a_r2_push_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == sp_q - AW'(1)) |=> (mem_we && mem_addr == $past(mem_addr) - AW'(1)));

  // R4: second pop read is one address above the first
  a_r4_pop_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_POP_L) |=> (mem_rd && mem_addr == $past(mem_addr) + AW'(1)));

  // R8: completed pop advances SP by two, wrapping
  a_r8_pop_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_POP_W) |=> (sp_q == $past(sp_q) + AW'(2)));

  // R3: no memory traffic while idle
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_rd));

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: interrupt-enable bits hold unless loaded while idle or restored by a pop
  a_r10_iff_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st_q != S_POP_W) |=> ($stable(iff1) && $stable(iff2)));

  // R9: a start while busy does not restart the sequence
  a_r9_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter logic [15:0] PC_RESET = 16'h0000,
  parameter logic [15:0] SP_RESET = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        ed_pfx,
  input  logic [7:0]  opcode,
  input  logic [15:0] operand,
  input  logic        cond_ok,
  input  logic        iff_we,
  input  logic        iff1_in,
  input  logic        iff2_in,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_rd,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] pc,
  output logic [15:0] sp,
  output logic        iff1,
  output logic        iff2,
  output logic        busy,
  output logic        done,
  output logic [4:0]  done_ts
);

  logic rst_meta_q, rst_sync_q;
  dec_t dec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  stack_seq_decode u_dec (
    .ed_pfx  (ed_pfx),
    .opcode  (opcode),
    .operand (operand),
    .cond_ok (cond_ok),
    .dec     (dec)
  );

  stack_seq_core #(
    .PC_RESET (PC_RESET),
    .SP_RESET (SP_RESET)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start     (start),
    .dec       (dec),
    .iff_we    (iff_we),
    .iff1_in   (iff1_in),
    .iff2_in   (iff2_in),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .pc        (pc),
    .sp        (sp),
    .iff1      (iff1),
    .iff2      (iff2),
    .busy      (busy),
    .done      (done),
    .done_ts   (done_ts)
  );

endmodule

// File: tb/stack_seq_test.sv
`timescale 1ns/1ps
module stack_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, ed_pfx = 1'b0, cond_ok = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] operand = '0;
  logic        iff_we = 1'b0, iff1_in = 1'b0, iff2_in = 1'b0;
  logic [15:0] mem_addr, pc, sp;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, mem_rd, iff1, iff2, busy, done;
  logic [4:0]  done_ts;

  logic [7:0]  mem [0:255];
  int total = 0, bad = 0;
  logic [15:0] m_pc, m_sp;
  logic        m_i1, m_i2;

  always #2.5 clk = ~clk;

  stack_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ed_pfx(ed_pfx), .opcode(opcode),
    .operand(operand), .cond_ok(cond_ok), .iff_we(iff_we), .iff1_in(iff1_in),
    .iff2_in(iff2_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata), .pc(pc), .sp(sp), .iff1(iff1),
    .iff2(iff2), .busy(busy), .done(done), .done_ts(done_ts)
  );

  // byte memory, low address byte selects the cell, read data one cycle late
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 11);
      mem_rdata <= '0;
    end else begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // issue one instruction and compare against the arithmetic model
  task automatic run(input logic [7:0] op, input logic ed, input logic [15:0] nn,
                     input logic cnd, input bit poke_busy);
    bit valid = 0, push = 0, pop = 0, skip = 0, nmi = 0;
    int ts = 0, lat = 0, exp_lat = 0;
    logic [15:0] ret = '0, exp_pc = m_pc, exp_sp = m_sp, popv;
    string tag = "R9";
    popv = {mem[8'(m_sp[7:0] + 8'd1)], mem[m_sp[7:0]]};
    if (ed) begin
      if (op == 8'h4D || op == 8'h45) begin
        valid = 1; pop = 1; ts = 14; nmi = (op == 8'h45); tag = "R7";
      end
    end else if (op == 8'hCD) begin
      valid = 1; push = 1; ts = 17; ret = m_pc + 16'd3; exp_pc = nn; tag = "R2";
    end else if (op[7:6] == 2'b11 && op[2:0] == 3'b100) begin
      valid = 1;
      if (cnd) begin push = 1; ts = 17; ret = m_pc + 16'd3; exp_pc = nn; tag = "R2"; end
      else begin skip = 1; ts = 10; exp_pc = m_pc + 16'd3; tag = "R3"; end
    end else if (op == 8'hC9) begin
      valid = 1; pop = 1; ts = 10; tag = "R4";
    end else if (op[7:6] == 2'b11 && op[2:0] == 3'b000) begin
      valid = 1;
      if (cnd) begin pop = 1; ts = 11; tag = "R4"; end
      else begin skip = 1; ts = 5; exp_pc = m_pc + 16'd1; tag = "R5"; end
    end else if (op[7:6] == 2'b11 && op[2:0] == 3'b111) begin
      valid = 1; push = 1; ts = 11; ret = m_pc + 16'd1;
      exp_pc = {10'd0, op[5:3], 3'b000}; tag = "R6";
    end
    if (push) begin exp_sp = m_sp - 16'd2; exp_lat = 3; end
    if (pop)  begin exp_sp = m_sp + 16'd2; exp_pc = popv; exp_lat = 4; end
    if (skip) exp_lat = 1;

    @(negedge clk);
    opcode = op; ed_pfx = ed; operand = nn; cond_ok = cnd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!valid) begin
      for (int k = 0; k < 3; k++) begin
        chk(!busy && !done, "R9 ignored opcode stays idle", busy, 0);
        @(negedge clk);
      end
      chk(pc == m_pc && sp == m_sp, "R9 ignored opcode keeps pc/sp", {pc, sp}, {m_pc, m_sp});
      return;
    end
    if (poke_busy) begin
      opcode = 8'hFF; ed_pfx = 1'b0; operand = 16'h5555; cond_ok = 1'b1; start = 1'b1;
    end
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
    chk(done_ts == 5'(ts), {tag, " done_ts"}, done_ts, ts);
    chk(pc == exp_pc, {tag, " pc"}, pc, exp_pc);
    chk(sp == exp_sp, {tag, " sp (R8 wrap)"}, sp, exp_sp);
    if (push) begin
      chk(mem[8'(m_sp[7:0] - 8'd1)] == ret[15:8], {tag, " pushed high byte"},
          mem[8'(m_sp[7:0] - 8'd1)], ret[15:8]);
      chk(mem[8'(m_sp[7:0] - 8'd2)] == ret[7:0], {tag, " pushed low byte"},
          mem[8'(m_sp[7:0] - 8'd2)], ret[7:0]);
    end
    if (nmi) m_i1 = m_i2;
    chk(iff1 == m_i1 && iff2 == m_i2, {tag, " iff pair"}, {iff1, iff2}, {m_i1, m_i2});
    @(negedge clk);
    chk(!done && done_ts == 0, "R11 done single pulse", {done, done_ts}, 0);
    m_pc = exp_pc; m_sp = exp_sp;
  endtask

  task automatic load_iff(input logic a, input logic b);
    @(negedge clk);
    iff_we = 1'b1; iff1_in = a; iff2_in = b;
    @(negedge clk);
    iff_we = 1'b0;
    m_i1 = a; m_i2 = b;
    chk(iff1 == a && iff2 == b, "R10 iff load while idle", {iff1, iff2}, {a, b});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(pc == 16'h0000, "R1 pc reset", pc, 0);
    chk(sp == 16'hFFFF, "R1 sp reset", sp, 16'hFFFF);
    chk(!busy && !done && !mem_we && !mem_rd && !iff1 && !iff2, "R1 idle outputs",
        {busy, done, mem_we, mem_rd, iff1, iff2}, 0);
    m_pc = 16'h0000; m_sp = 16'hFFFF; m_i1 = 0; m_i2 = 0;

    // R8: pop from 0xFFFF reads 0xFFFF and 0x0000, sp wraps to 0x0001
    run(8'hC9, 1'b0, 16'h0000, 1'b0, 0);
    chk(sp == 16'h0001, "R8 sp wraps on pop", sp, 16'h0001);
    // R8: push from 0x0001 writes 0x0000 then 0xFFFF, sp becomes 0xFFFF
    run(8'hCD, 1'b0, 16'h1234, 1'b0, 0);
    chk(sp == 16'hFFFF, "R8 sp wraps on push", sp, 16'hFFFF);

    // R9: start while busy ignored (a restart is offered mid-call)
    run(8'hCD, 1'b0, 16'hA5C3, 1'b0, 1);
    chk(pc == 16'hA5C3, "R9 busy start ignored", pc, 16'hA5C3);

    // R7 / R10: non-maskable return copies iff2 to iff1, interrupt return does not
    load_iff(1'b0, 1'b1);
    run(8'h4D, 1'b1, 16'h0000, 1'b0, 0);
    chk(iff1 == 1'b0, "R7 interrupt return keeps iff1", iff1, 0);
    run(8'h45, 1'b1, 16'h0000, 1'b0, 0);
    chk(iff1 == 1'b1, "R7 non-maskable return copies iff2", iff1, 1);
    load_iff(1'b1, 1'b0);
    run(8'h45, 1'b1, 16'h0000, 1'b0, 0);
    chk(iff1 == 1'b0, "R7 non-maskable return clears iff1", iff1, 0);

    // R10: load strobe ignored while busy
    @(negedge clk);
    opcode = 8'hCD; ed_pfx = 1'b0; operand = 16'h0200; start = 1'b1;
    @(negedge clk);
    start = 1'b0; iff_we = 1'b1; iff1_in = 1'b1; iff2_in = 1'b1;
    @(negedge clk);
    iff_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(iff1 == 1'b0 && iff2 == 1'b0, "R10 iff load ignored while busy", {iff1, iff2}, 0);
    m_pc = 16'h0200; m_sp = m_sp - 16'd2;

    // full sweep: every opcode, both condition values, plain and prefixed
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 256; o++)
        run(8'(o), 1'b0, {8'(o), 8'(~o)} ^ 16'h3C00, c[0], 0);
    for (int o = 0; o < 256; o++)
      run(8'(o), 1'b1, 16'h0000, 1'b1, 0);

    summary();
    $finish;
  end

endmodule